// File: doc/BRIEF.md
# Interrupt Aggregator with Per-Source Vector Routing

This block gathers up to 64 interrupt lines. For each line it keeps a request bit and an in-service bit. Each line can be set to edge or level sensing, and each can be masked. When a source's state changes, the block sends an event downstream. The event carries the 8-bit vector that software stored for that source, not the source number. A level bit in the event says whether the interrupt is being raised or withdrawn. Software reaches the block through a simple 32-bit register port. Every 64-bit register appears as a lower and an upper word, selected by byte-address bit 2.

A register write can affect many sources at once, for example an unmask or a write-one-to-clear. The block marks every affected source for re-evaluation. A scanner then visits the marked sources one per cycle, in a fixed order. Events leave through a valid/ready port. While `ev_ready` is low, the current event is held unchanged and the scanner stops. Mask and clear writes that would add more work are stalled (`bus_ready` low) while any re-evaluation or event is outstanding. Other writes and all reads are accepted at once, and `bus_rdata` follows `bus_addr` combinationally.

Register map (byte addresses; `+4` selects the upper word):

| Address | Register |
|---|---|
| 0x000 | identification word |
| 0x020 | mask |
| 0x040 | sense select |
| 0x060 | clear (write-one) |
| 0x080 | request |
| 0x0A0 | in-service |
| 0x0C0 | polarity |
| 0x0E0 | distribution control |
| 0x100+4i | route entry of source i |
| 0x200+4i | vector of source i, in bits 7:0 |

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the mask, sense-select, request and in-service registers and all vectors are zero, `ev_valid` is low and `bus_ready` is high.
- R2: Byte-address bit 2 selects the upper (1) or lower (0) 32 bits of a 64-bit register, and a write changes only the selected half.
- R3: A rising input sets that source's request bit. A falling input clears it when the sense-select bit is 0 (level). The request bit is kept when the sense-select bit is 1 (edge).
- R4: A source that is requesting, unmasked and not in service gets its in-service bit set. It also emits an event with level 1 and its own vector, on the second clock edge after the input is first sampled high.
- R5: An in-service source whose request has dropped gets its in-service bit cleared and emits an event with level 0 and its vector.
- R6: A source that requests while masked emits nothing. Clearing its mask bit (1 to 0) re-evaluates it with level high, which raises it. Unmasking a source already in service emits nothing.
- R7: Setting a mask bit (0 to 1) re-evaluates the source with level low. If the source is still requesting, it stays in service and no event is sent.
- R8: A write of ones to the clear register clears only request bits that are set and edge-sensed. Each cleared source is then re-evaluated low and emits a level-0 event.
- R9: Sources marked by one write or one input change are handled one per cycle, in ascending index order. Raise re-evaluations go before lower re-evaluations.
- R10: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_vector` and `ev_level` hold steady, and later events wait.
- R11: A mask or clear write sees `bus_ready` low while an event or re-evaluation is outstanding.
- R12: Each vector entry is read and written on its own at 0x200+4i, using bits 7:0. Writing one entry leaves the others unchanged.
- R13: The identification word reads `ID_LO` in its lower 32 bits. The upper word holds `VERSION` in bits 7:0 and the constant 31 in bits 23:16, which are bits 48 and up of the 64-bit word.
- R14: The polarity and distribution-control registers read zero whatever was written, and every route entry reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| irq_in | input | NSRC | interrupt lines, synchronous, active high |
| bus_req | input | 1 | register access request |
| bus_we | input | 1 | 1 = write |
| bus_addr | input | 10 | byte address, word aligned |
| bus_wdata | input | 32 | write data |
| bus_ready | output | 1 | write accepted on this edge when high |
| bus_rdata | output | 32 | read data for `bus_addr` |
| ev_valid | output | 1 | downstream event present |
| ev_ready | input | 1 | downstream accepts event |
| ev_vector | output | 8 | vector of the event's source |
| ev_level | output | 1 | 1 = raise, 0 = withdraw |

## Verification
The assertions check four rules on every cycle. A held event stays stable under back-pressure. Mask and clear writes are refused while work is outstanding. An in-service bit only sets for an unmasked requester and only clears for a non-requester. At most one in-service bit changes per cycle, and every new event has a matching in-service change. Only the bench scenarios can show the rest: which vector each event carries, the ascending order within a burst, the separate edge and level release paths, the halves of the register port, and the constant registers.

// File: rtl/agg_pkg.sv
package agg_pkg;
  localparam int VEC_W  = 8;
  localparam int ADDR_W = 10;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_MASK, SEL_EDGE, SEL_CLEAR,
    SEL_REQ, SEL_ISR, SEL_ZERO, SEL_ROUTE, SEL_VEC
  } sel_e;

  typedef struct packed {
    logic             level;
    logic [VEC_W-1:0] vec;
  } irq_event_t;

  // Word-aligned decode. Bit 2 picks the half of 64-bit registers.
  function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
    sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (a[9:8] == 2'b10)      s = SEL_VEC;
      else if (a[9:8] == 2'b01) s = SEL_ROUTE;
      else if (a[9:8] == 2'b00) begin
        case (a[7:3])
          5'h00:        s = SEL_ID;
          5'h04:        s = SEL_MASK;
          5'h08:        s = SEL_EDGE;
          5'h0C:        s = SEL_CLEAR;
          5'h10:        s = SEL_REQ;
          5'h14:        s = SEL_ISR;
          5'h18, 5'h1C: s = SEL_ZERO;
          default:      s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction

  function automatic logic [63:0] merge_half(input logic [63:0] old,
                                             input logic hi,
                                             input logic [31:0] d);
    return hi ? {d, old[31:0]} : {old[63:32], d};
  endfunction
endpackage

// File: rtl/agg_lowest.sv
module agg_lowest #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |bits;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/agg_regs.sv
module agg_regs
  import agg_pkg::*;
#(
  parameter int          NSRC    = 64,
  parameter logic [31:0] ID_LO   = 32'h4943_0001,
  parameter logic [7:0]  VERSION = 8'h02
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  input  logic [NSRC-1:0]       req_vec,
  input  logic [NSRC-1:0]       isr_vec,
  output logic [NSRC-1:0]       mask_vec,
  output logic [NSRC-1:0]       edge_vec,
  output logic [NSRC-1:0]       unmask_bits,
  output logic [NSRC-1:0]       newmask_bits,
  output logic [NSRC-1:0]       clear_bits,
  output logic [NSRC*VEC_W-1:0] vec_flat,
  output logic [31:0]           rdata
);
  localparam int TIW = 6;
  localparam logic [63:0] ID_WORD = {8'h00, 8'd31, 8'h00, VERSION, ID_LO};

  sel_e             sel;
  logic             hi;
  logic [TIW-1:0]   vidx;
  logic             vidx_ok;
  logic [63:0]      mask_new, edge_new, clr64, r64;
  logic             mask_wr, edge_wr, vec_wr;
  logic [VEC_W-1:0] vtab [NSRC];

  always_comb begin
    sel      = decode_addr(addr);
    hi       = addr[2];
    vidx     = addr[7:2];
    vidx_ok  = int'(vidx) < NSRC;
    mask_wr  = wr_fire && (sel == SEL_MASK);
    edge_wr  = wr_fire && (sel == SEL_EDGE);
    vec_wr   = wr_fire && (sel == SEL_VEC) && vidx_ok;
    mask_new = merge_half(64'(mask_vec), hi, wdata);
    edge_new = merge_half(64'(edge_vec), hi, wdata);
    clr64    = merge_half(64'(0), hi, wdata);
  end

  assign unmask_bits  = mask_wr ? (mask_vec & ~mask_new[NSRC-1:0]) : '0;
  assign newmask_bits = mask_wr ? (~mask_vec & mask_new[NSRC-1:0]) : '0;
  assign clear_bits   = (wr_fire && (sel == SEL_CLEAR)) ? clr64[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_vec <= '0;
      edge_vec <= '0;
      for (int i = 0; i < NSRC; i++) vtab[i] <= '0;
    end else begin
      if (mask_wr) mask_vec <= mask_new[NSRC-1:0];
      if (edge_wr) edge_vec <= edge_new[NSRC-1:0];
      if (vec_wr)  vtab[vidx] <= wdata[VEC_W-1:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_flat
    assign vec_flat[g*VEC_W +: VEC_W] = vtab[g];
  end

  always_comb begin
    r64 = '0;
    case (sel)
      SEL_ID:    r64 = ID_WORD;
      SEL_MASK:  r64 = 64'(mask_vec);
      SEL_EDGE:  r64 = 64'(edge_vec);
      SEL_REQ:   r64 = 64'(req_vec);
      SEL_ISR:   r64 = 64'(isr_vec);
      SEL_ROUTE: r64 = 64'(1);
      SEL_VEC:   r64 = vidx_ok ? 64'(vtab[vidx]) : '0;
      default:   r64 = '0;
    endcase
    if (sel == SEL_ROUTE || sel == SEL_VEC) rdata = r64[31:0];
    else                                    rdata = hi ? r64[63:32] : r64[31:0];
  end
endmodule

// File: rtl/agg_track.sv
module agg_track
  import agg_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_in,
  input  logic [NSRC-1:0]       edge_vec,
  input  logic [NSRC-1:0]       mask_vec,
  input  logic [NSRC-1:0]       unmask_bits,
  input  logic [NSRC-1:0]       newmask_bits,
  input  logic [NSRC-1:0]       clear_bits,
  input  logic [NSRC*VEC_W-1:0] vec_flat,
  input  logic                  ev_ready,
  output logic [NSRC-1:0]       req_vec,
  output logic [NSRC-1:0]       isr_vec,
  output logic                  busy,
  output logic                  ev_valid,
  output irq_event_t            ev_out
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] line_q, pend_up, pend_dn;
  logic [NSRC-1:0] rise, lvl_fall, clr_hit, pick_oh;
  logic            up_found, dn_found, slot_free, go, use_up;
  logic            fire_set, fire_clr;
  logic [IW-1:0]   up_idx, dn_idx, pick;

  agg_lowest #(.N(NSRC), .IW(IW)) u_up (.bits(pend_up), .found(up_found), .idx(up_idx));
  agg_lowest #(.N(NSRC), .IW(IW)) u_dn (.bits(pend_dn), .found(dn_found), .idx(dn_idx));

  always_comb begin
    rise      = irq_in & ~line_q;
    lvl_fall  = ~irq_in & line_q & ~edge_vec;
    clr_hit   = clear_bits & req_vec & edge_vec;
    slot_free = !ev_valid || ev_ready;
    use_up    = up_found;
    go        = slot_free && (up_found || dn_found);
    pick      = use_up ? up_idx : dn_idx;
    pick_oh   = go ? (NSRC'(1) << pick) : '0;
    fire_set  = go && use_up && req_vec[pick] && !mask_vec[pick] && !isr_vec[pick];
    fire_clr  = go && !use_up && isr_vec[pick] && !req_vec[pick];
  end

  assign busy = (|pend_up) || (|pend_dn) || ev_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      req_vec  <= '0;
      isr_vec  <= '0;
      pend_up  <= '0;
      pend_dn  <= '0;
      ev_valid <= 1'b0;
      ev_out   <= '0;
    end else begin
      line_q  <= irq_in;
      req_vec <= (req_vec & ~clr_hit & ~lvl_fall) | rise;
      pend_up <= (pend_up & ~(use_up ? pick_oh : '0)) | rise | unmask_bits;
      pend_dn <= (pend_dn & ~(use_up ? '0 : pick_oh)) | lvl_fall | newmask_bits | clr_hit;
      if (fire_set) isr_vec[pick] <= 1'b1;
      if (fire_clr) isr_vec[pick] <= 1'b0;
      if (slot_free) begin
        ev_valid     <= fire_set || fire_clr;
        ev_out.level <= fire_set;
        ev_out.vec   <= vec_flat[pick*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import agg_pkg::*;
#(
  parameter int          NSRC    = 64,
  parameter logic [31:0] ID_LO   = 32'h4943_0001,
  parameter logic [7:0]  VERSION = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [VEC_W-1:0]  ev_vector,
  output logic              ev_level
);
  sel_e                  sel;
  logic                  busy, wr_fire;
  logic [NSRC-1:0]       req_vec, isr_vec, mask_vec, edge_vec;
  logic [NSRC-1:0]       unmask_bits, newmask_bits, clear_bits;
  logic [NSRC*VEC_W-1:0] vec_flat;
  irq_event_t            ev_out;

  always_comb begin
    sel       = decode_addr(bus_addr);
    bus_ready = !(busy && (sel == SEL_MASK || sel == SEL_CLEAR));
    wr_fire   = bus_req && bus_we && bus_ready;
  end

  agg_regs #(.NSRC(NSRC), .ID_LO(ID_LO), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr(bus_addr), .wdata(bus_wdata),
    .req_vec(req_vec), .isr_vec(isr_vec), .mask_vec(mask_vec), .edge_vec(edge_vec),
    .unmask_bits(unmask_bits), .newmask_bits(newmask_bits), .clear_bits(clear_bits),
    .vec_flat(vec_flat), .rdata(bus_rdata)
  );

  agg_track #(.NSRC(NSRC)) u_track (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_vec(edge_vec), .mask_vec(mask_vec),
    .unmask_bits(unmask_bits), .newmask_bits(newmask_bits), .clear_bits(clear_bits),
    .vec_flat(vec_flat), .ev_ready(ev_ready), .req_vec(req_vec), .isr_vec(isr_vec),
    .busy(busy), .ev_valid(ev_valid), .ev_out(ev_out)
  );

  assign ev_vector = ev_out.vec;
  assign ev_level  = ev_out.level;
endmodule

// File: rtl/agg_checker.sv
module agg_checker
  import agg_pkg::*;
#(
  parameter int NSRC = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [VEC_W-1:0]  ev_vector,
  input logic              ev_level,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic [NSRC-1:0]   req_vec,
  input logic [NSRC-1:0]   isr_vec,
  input logic [NSRC-1:0]   mask_vec
);
  sel_e chk_sel;
  assign chk_sel = decode_addr(bus_addr);

  AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_vector) && $stable(ev_level))); // R10

  AST_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && ev_valid && (chk_sel == SEL_MASK || chk_sel == SEL_CLEAR)) |-> !bus_ready); // R11

  AST_SET_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_vec & ~$past(isr_vec) & ~$past(req_vec & ~mask_vec)) == '0)); // R4

  AST_CLEAR_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~isr_vec & $past(isr_vec) & $past(req_vec)) == '0)); // R5

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_vec ^ $past(isr_vec)) <= 1); // R9

  AST_EVENT_HAS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && (!$past(ev_valid) || $past(ev_ready))) |-> ($countones(isr_vec ^ $past(isr_vec)) == 1)); // R4
endmodule

bind irq_aggregator agg_checker #(.NSRC(NSRC)) u_agg_checker (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_vector(ev_vector), .ev_level(ev_level), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_ready(bus_ready), .req_vec(req_vec), .isr_vec(isr_vec),
  .mask_vec(mask_vec)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int          NSRC    = 64;
  localparam logic [31:0] ID_LO   = 32'h4943_0001;
  localparam logic [7:0]  VERSION = 8'h02;
  localparam logic [9:0]  A_ID = 10'h000, A_MASK = 10'h020, A_EDGE = 10'h040, A_CLR = 10'h060;
  localparam logic [9:0]  A_REQ = 10'h080, A_ISR = 10'h0A0, A_POL = 10'h0C0, A_DIST = 10'h0E0;
  localparam logic [9:0]  A_ROUTE = 10'h100, A_VEC = 10'h200;
  // {edge mode, source, vector}
  localparam logic [14:0] ROWS [6] = '{
    {1'b0, 6'd0,  8'h10}, {1'b1, 6'd1,  8'h21}, {1'b0, 6'd31, 8'h7F},
    {1'b1, 6'd32, 8'h80}, {1'b0, 6'd47, 8'hC3}, {1'b1, 6'd63, 8'hFE}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, bus_req, bus_we, bus_ready, ev_valid, ev_ready, ev_level;
  logic [NSRC-1:0] irq_in;
  logic [9:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata, rv;
  logic [7:0]      ev_vector;
  int n_checks = 0, n_fail = 0;

  irq_aggregator #(.NSRC(NSRC), .ID_LO(ID_LO), .VERSION(VERSION)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_vector(ev_vector), .ev_level(ev_level)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #0.1;
    while (!bus_ready) begin @(negedge clk); #0.1; end
    @(posedge clk); #0.1;
    bus_req = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic expect_ev(input string tag, input bit v, input logic [7:0] vec, input bit lvl);
    if (v) check(ev_valid === 1'b1 && ev_vector === vec && ev_level === lvl, tag,
                 {ev_valid, ev_level, ev_vector}, {1'b1, lvl, vec});
    else   check(ev_valid === 1'b0, tag, 64'(ev_valid), 64'(0));
  endtask

  function automatic logic [9:0] half(input logic [9:0] base, input int s);
    return base + ((s >= 32) ? 10'd4 : 10'd0);
  endfunction

  function automatic logic [31:0] bitw(input int s);
    return 32'(1) << (s % 32);
  endfunction

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    ev_ready = 1'b1; irq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 reset state
    expect_ev("R1 ev_valid", 1'b0, 8'h00, 1'b0);
    bus_addr = A_MASK; #0.1;
    check(bus_ready === 1'b1, "R1 bus_ready", 64'(bus_ready), 64'(1));
    rd(A_MASK, rv);    check(rv === 32'h0, "R1 mask", rv, 0);
    rd(A_EDGE + 4, rv); check(rv === 32'h0, "R1 edge", rv, 0);
    rd(A_ISR, rv);     check(rv === 32'h0, "R1 isr", rv, 0);
    rd(A_VEC + 4*5, rv); check(rv === 32'h0, "R1 vector", rv, 0);
    step();

    // Table walk: R3 R4 R5 R8
    for (int r = 0; r < 6; r++) begin
      bit md; int s; logic [7:0] v;
      md = ROWS[r][14]; s = int'(ROWS[r][13:8]); v = ROWS[r][7:0];
      wr(A_VEC + 10'(4*s), 32'(v));
      if (md) wr(half(A_EDGE, s), bitw(s));
      irq_in[s] = 1'b1;
      step(); expect_ev("R4 no early event", 1'b0, 8'h00, 1'b0);
      step(); expect_ev("R4 raise event", 1'b1, v, 1'b1);
      rd(half(A_ISR, s), rv); check(rv === bitw(s), "R4 in-service bit", rv, bitw(s));
      irq_in[s] = 1'b0;
      step(); step();
      if (!md) begin
        expect_ev("R5 level withdraw", 1'b1, v, 1'b0);
        step();
        rd(half(A_REQ, s), rv); check(rv === 32'h0, "R3 level fall clears", rv, 0);
      end else begin
        expect_ev("R3 edge fall silent", 1'b0, 8'h00, 1'b0);
        rd(half(A_REQ, s), rv); check(rv === bitw(s), "R3 edge fall keeps", rv, bitw(s));
        wr(half(A_CLR, s), bitw(s));
        step(); expect_ev("R8 clear withdraw", 1'b1, v, 1'b0);
        step();
        wr(half(A_EDGE, s), 32'h0);
      end
    end

    // R6 / R9: masked requests then unmask burst
    wr(A_VEC + 4*3, 32'h33); wr(A_VEC + 4*5, 32'h55); wr(A_VEC + 4*9, 32'h99);
    wr(A_MASK, 32'h228);
    irq_in[3] = 1'b1; irq_in[5] = 1'b1; irq_in[9] = 1'b1;
    repeat (6) step();
    expect_ev("R6 masked silent", 1'b0, 8'h00, 1'b0);
    rd(A_ISR, rv); check(rv === 32'h0, "R6 masked not in service", rv, 0);
    wr(A_MASK, 32'h0);
    step(); expect_ev("R9 first 3",  1'b1, 8'h33, 1'b1);
    step(); expect_ev("R9 second 5", 1'b1, 8'h55, 1'b1);
    step(); expect_ev("R9 third 9",  1'b1, 8'h99, 1'b1);
    step(); expect_ev("R9 burst end", 1'b0, 8'h00, 1'b0);

    // R7 masking a requesting in-service source
    wr(A_MASK, 32'h200);
    repeat (3) step();
    expect_ev("R7 mask no event", 1'b0, 8'h00, 1'b0);
    rd(A_ISR, rv); check(rv === 32'h228, "R7 stays in service", rv, 32'h228);
    wr(A_MASK, 32'h0);
    repeat (2) step();
    expect_ev("R6 unmask in-service silent", 1'b0, 8'h00, 1'b0);
    irq_in[3] = 1'b0; irq_in[5] = 1'b0; irq_in[9] = 1'b0;
    step(); step(); expect_ev("R9 withdraw 3", 1'b1, 8'h33, 1'b0);
    step(); expect_ev("R9 withdraw 5", 1'b1, 8'h55, 1'b0);
    step(); expect_ev("R9 withdraw 9", 1'b1, 8'h99, 1'b0);
    step(); expect_ev("R9 withdraw end", 1'b0, 8'h00, 1'b0);

    // R10 / R11 back-pressure
    wr(A_VEC + 4*20, 32'h14); wr(A_VEC + 4*21, 32'h15);
    ev_ready = 1'b0;
    irq_in[20] = 1'b1;
    step(); step(); expect_ev("R10 first event", 1'b1, 8'h14, 1'b1);
    irq_in[21] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(); expect_ev("R10 held", 1'b1, 8'h14, 1'b1);
    end
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_MASK; bus_wdata = 32'h0; #0.1;
    check(bus_ready === 1'b0, "R11 mask write stalled", 64'(bus_ready), 64'(0));
    bus_addr = A_CLR; #0.1;
    check(bus_ready === 1'b0, "R11 clear write stalled", 64'(bus_ready), 64'(0));
    bus_req = 1'b0; bus_we = 1'b0;
    ev_ready = 1'b1;
    step(); expect_ev("R10 next after ready", 1'b1, 8'h15, 1'b1);
    step(); expect_ev("R10 drained", 1'b0, 8'h00, 1'b0);
    irq_in[20] = 1'b0; irq_in[21] = 1'b0;
    step(); step(); expect_ev("R10 withdraw 20", 1'b1, 8'h14, 1'b0);
    step(); expect_ev("R10 withdraw 21", 1'b1, 8'h15, 1'b0);
    step();

    // R2 halves
    wr(A_MASK + 4, 32'hCAFE_0000);
    wr(A_MASK, 32'h0000_0F00);
    rd(A_MASK + 4, rv); check(rv === 32'hCAFE_0000, "R2 upper half", rv, 32'hCAFE_0000);
    rd(A_MASK, rv);     check(rv === 32'h0000_0F00, "R2 lower half", rv, 32'h0000_0F00);
    wr(A_MASK, 32'h0);
    rd(A_MASK + 4, rv); check(rv === 32'hCAFE_0000, "R2 upper kept", rv, 32'hCAFE_0000);
    wr(A_MASK + 4, 32'h0);
    step(); step();
    expect_ev("R2 idle unmask silent", 1'b0, 8'h00, 1'b0);

    // R12 vectors
    wr(A_VEC + 4*63, 32'hABCD_EF5A);
    rd(A_VEC + 4*63, rv); check(rv === 32'h5A, "R12 vector low byte", rv, 32'h5A);
    rd(A_VEC + 4*62, rv); check(rv === 32'h0, "R12 neighbour untouched", rv, 0);

    // R13 identification
    rd(A_ID, rv);     check(rv === ID_LO, "R13 id low", rv, ID_LO);
    rd(A_ID + 4, rv); check(rv === {8'h00, 8'd31, 8'h00, VERSION}, "R13 id high", rv,
                            {8'h00, 8'd31, 8'h00, VERSION});
    step();

    // R14 constant registers
    wr(A_POL, 32'hFFFF_FFFF);
    rd(A_POL, rv);  check(rv === 32'h0, "R14 polarity zero", rv, 0);
    wr(A_DIST + 4, 32'h1234_5678);
    rd(A_DIST + 4, rv); check(rv === 32'h0, "R14 distribution zero", rv, 0);
    wr(A_ROUTE + 4*7, 32'h0);
    rd(A_ROUTE + 4*7, rv); check(rv === 32'h1, "R14 route one", rv, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule